// File: doc/BRIEF.md
# Key-Locked Scaled Watchdog Timer

This block is a watchdog for an always-on power domain. A free-running 31-bit counter advances on ticks of a slow clock. The tick arrives as a one-cycle enable strobe in the bus clock domain. The counter only advances when software has enabled it. A programmable right shift turns the raw count into a 16-bit scaled value, which is compared against a 16-bit threshold.

When the scaled value reaches the threshold, the block takes these actions:
- It sets a sticky pending flag, which drives the interrupt output.
- It can optionally zero the counter, which makes it a periodic timer.
- It can optionally pulse a system reset request.

Every register that changes the timer's behaviour is guarded by a single-use key. Software writes a magic word to the key register. The next protected write is accepted. Any protected write, accepted or not, clears the key again.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block reads as follows: configuration word (0x00) is 0, raw count (0x08) is 0, threshold (0x20) is 0xBEEF, key flag (0x1C) is 0 and feed (0x18) is 0. Both `irq` and `rst_req` are low.
- R2: Writing 0x0051F15E to offset 0x1C sets the key flag, which reads back in bit 0 of 0x1C. Any other value written there leaves the flag unchanged.
- R3: A write to 0x00, 0x08, 0x18 or 0x20 is discarded when the key flag is clear. Every such write clears the flag, whether it is accepted or discarded.
- R4: The raw count at 0x08 rises by one on each cycle with `tick` high while configuration bit 12 or bit 13 is set. It holds otherwise. It wraps from 0x7FFFFFFF to 0, and bit 31 of the read is always 0.
- R5: Offset 0x10 reads the raw count shifted right by configuration bits 3:0, keeping the low 16 bits. Writes to 0x10 change nothing.
- R6: An accepted write of 0x0D09F00D to 0x18 clears the raw count. An accepted write of any other value leaves the count unchanged but still uses up the key. Offset 0x18 always reads 0.
- R7: Once the scaled value is greater than or equal to the threshold, configuration bit 28 and `irq` are high from the next cycle. They stay high until a configuration write clears bit 28 while no match is present.
- R8: With configuration bit 9 set, a match clears the raw count on the next clock.
- R9: With configuration bit 8 set, `rst_req` pulses high for exactly one cycle when a match begins. With bit 8 clear, `rst_req` stays low.
- R10: An accepted write to 0x08 loads write-data bits 30:0. This load wins over a `tick` in the same cycle.
- R11: An accepted write to 0x20 stores the low 16 bits of the write data as the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per slow-clock tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt, equals the pending flag |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A slow-clock tick and a software load of the raw count can land in the same clock. The bench raises `tick` during the very cycle of an accepted count write, then reads the count back. It expects exactly the written value, not that value plus one. The bench also holds a match condition while software tries to clear the pending flag. It expects the flag to be set again, because the set from the compare wins over the clear from the write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int OFF_CFG    = 'h00;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_SCALED = 'h10;
  localparam int OFF_FEED   = 'h18;
  localparam int OFF_KEY    = 'h1C;
  localparam int OFF_THRESH = 'h20;

  localparam logic [31:0] KEY_WORD  = 32'h0051_F15E;
  localparam logic [31:0] FEED_WORD = 32'h0D09_F00D;

  localparam int B_RSTEN = 8;
  localparam int B_ZCMP  = 9;
  localparam int B_ENA   = 12;
  localparam int B_ENB   = 13;
  localparam int B_PEND  = 28;

  localparam logic [15:0] THRESH_RESET = 16'hBEEF;
endpackage

// File: rtl/kwd_unlock.sv
module kwd_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr_i,
  input  logic key_ok_i,
  input  logic prot_wr_i,
  output logic unlocked_o
);
  logic unl_q, unl_d;

  always_comb begin
    unl_d = unl_q;
    if (key_wr_i && key_ok_i) unl_d = 1'b1;
    else if (prot_wr_i)       unl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unl_q <= 1'b0;
    else        unl_q <= unl_d;
  end

  assign unlocked_o = unl_q;

  assert_key_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_i |=> !unlocked_o);
  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr_i && key_ok_i) |=> unlocked_o);
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_val_i,
  input  logic               feed_i,
  input  logic               zcmp_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [CMP_W-1:0]   thresh_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CMP_W-1:0]   scaled_o,
  output logic               hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, shifted;

  always_comb begin
    shifted  = cnt_q >> scale_i;
    scaled_o = shifted[CMP_W-1:0];
    hit_o    = (scaled_o >= thresh_i);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                       cnt_d = load_val_i;
    else if (feed_i || (hit_o && zcmp_i)) cnt_d = '0;
    else if (tick_i && en_i)          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i)));
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !feed_i && !(hit_o && zcmp_i) && !(tick_i && en_i)) |=> $stable(cnt_o));
  assert_zero_on_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && zcmp_i && !load_i) |=> (cnt_o == '0));
endmodule

// File: rtl/kwd_event.sv
module kwd_event (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic rsten_i,
  input  logic cfg_wr_i,
  input  logic pend_wval_i,
  output logic pend_o,
  output logic rst_req_o
);
  logic pend_q, pend_d, hit_q, req_q, req_d;

  always_comb begin
    pend_d = hit_i | (cfg_wr_i ? pend_wval_i : pend_q);
    req_d  = hit_i & ~hit_q & rsten_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hit_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hit_q  <= hit_i;
      req_q  <= req_d;
    end
  end

  assign pend_o    = pend_q;
  assign rst_req_o = req_q;

  assert_match_sets_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> pend_o);
  assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !pend_wval_i && !hit_i) |=> !pend_o);
  assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 31,
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int SYNC_STAGES = 2;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync;
  logic rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync[SYNC_STAGES-1];

  logic sel_cfg, sel_cnt, sel_scl, sel_feed, sel_key, sel_thr;
  always_comb begin
    sel_cfg  = (addr == ADDR_W'(OFF_CFG));
    sel_cnt  = (addr == ADDR_W'(OFF_COUNT));
    sel_scl  = (addr == ADDR_W'(OFF_SCALED));
    sel_feed = (addr == ADDR_W'(OFF_FEED));
    sel_key  = (addr == ADDR_W'(OFF_KEY));
    sel_thr  = (addr == ADDR_W'(OFF_THRESH));
  end

  logic unlocked, prot_wr, acc_cfg, acc_cnt, acc_feed, acc_thr;
  always_comb begin
    prot_wr  = wr_en & (sel_cfg | sel_cnt | sel_feed | sel_thr);
    acc_cfg  = wr_en & unlocked & sel_cfg;
    acc_cnt  = wr_en & unlocked & sel_cnt;
    acc_feed = wr_en & unlocked & sel_feed & (wdata == FEED_WORD);
    acc_thr  = wr_en & unlocked & sel_thr;
  end

  kwd_unlock u_unlock (
    .clk        (clk),
    .rst_n      (rst_ni),
    .key_wr_i   (wr_en & sel_key),
    .key_ok_i   (wdata == KEY_WORD),
    .prot_wr_i  (prot_wr),
    .unlocked_o (unlocked)
  );

  // configuration and threshold storage
  logic [SCALE_W-1:0] scale_q;
  logic rsten_q, zcmp_q, ena_q, enb_q;
  logic [CMP_W-1:0] thr_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= '0;
      rsten_q <= 1'b0;
      zcmp_q  <= 1'b0;
      ena_q   <= 1'b0;
      enb_q   <= 1'b0;
    end else if (acc_cfg) begin
      scale_q <= wdata[SCALE_W-1:0];
      rsten_q <= wdata[B_RSTEN];
      zcmp_q  <= wdata[B_ZCMP];
      ena_q   <= wdata[B_ENA];
      enb_q   <= wdata[B_ENB];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      thr_q <= THRESH_RESET[CMP_W-1:0];
    else if (acc_thr) thr_q <= wdata[CMP_W-1:0];
  end

  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] scaled;
  logic hit, pend;

  kwd_count #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_ni),
    .tick_i     (tick),
    .en_i       (ena_q | enb_q),
    .load_i     (acc_cnt),
    .load_val_i (wdata[CNT_W-1:0]),
    .feed_i     (acc_feed),
    .zcmp_i     (zcmp_q),
    .scale_i    (scale_q),
    .thresh_i   (thr_q),
    .cnt_o      (cnt),
    .scaled_o   (scaled),
    .hit_o      (hit)
  );

  kwd_event u_event (
    .clk         (clk),
    .rst_n       (rst_ni),
    .hit_i       (hit),
    .rsten_i     (rsten_q),
    .cfg_wr_i    (acc_cfg),
    .pend_wval_i (wdata[B_PEND]),
    .pend_o      (pend),
    .rst_req_o   (rst_req)
  );

  assign irq = pend;

  always_comb begin
    rdata = '0;
    if (sel_cfg) begin
      rdata[SCALE_W-1:0] = scale_q;
      rdata[B_RSTEN]     = rsten_q;
      rdata[B_ZCMP]      = zcmp_q;
      rdata[B_ENA]       = ena_q;
      rdata[B_ENB]       = enb_q;
      rdata[B_PEND]      = pend;
    end else if (sel_cnt) begin
      rdata[CNT_W-1:0] = cnt;
    end else if (sel_scl) begin
      rdata[CMP_W-1:0] = scaled;
    end else if (sel_key) begin
      rdata[0] = unlocked;
    end else if (sel_thr) begin
      rdata[CMP_W-1:0] = thr_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assert_cnt_msb_zero_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    sel_cnt |-> !rdata[DATA_W-1]);
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic clk, rst_n, tick, wr_en, irq, rst_req;
  logic [5:0] addr;
  logic [31:0] wdata, rdata, v;
  int n_chk, n_fail, n_pulse;
  bit done;

  localparam logic [31:0] KEY  = 32'h0051_F15E;
  localparam logic [31:0] FEED = 32'h0D09_F00D;

  keyed_watchdog uut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (rst_req) n_pulse++;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic t);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic kwr(input logic [5:0] a, input logic [31:0] d, input logic t);
    wr(6'h1C, KEY, 1'b0);
    wr(a, d, t);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // scale, raw count, expected scaled value
  localparam logic [50:0] VEC [5] = '{
    {4'd0,  31'h0000_1234, 16'h1234},
    {4'd4,  31'h0001_2345, 16'h1234},
    {4'd8,  31'h7FFF_FFFF, 16'hFFFF},
    {4'd15, 31'h7FFF_8000, 16'hFFFF},
    {4'd3,  31'h0000_0040, 16'h0008}
  };

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; n_pulse = 0; done = 1'b0;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(6'h00, v); check("R1 cfg", v, 32'h0);
    rd(6'h08, v); check("R1 count", v, 32'h0);
    rd(6'h20, v); check("R1 thresh", v, 32'h0000_BEEF);
    rd(6'h1C, v); check("R1 key", v, 32'h0);
    rd(6'h18, v); check("R1 feed", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);

    // R2 key
    wr(6'h1C, 32'h1234_5678, 1'b0);
    rd(6'h1C, v); check("R2 wrong key", v, 32'h0);
    wr(6'h1C, KEY, 1'b0);
    rd(6'h1C, v); check("R2 key set", v, 32'h1);

    // R11 / R3
    wr(6'h20, 32'hABCD_1234, 1'b0);
    rd(6'h20, v); check("R11 thresh", v, 32'h0000_1234);
    rd(6'h1C, v); check("R3 key consumed", v, 32'h0);
    wr(6'h20, 32'h5555, 1'b0);
    rd(6'h20, v); check("R3 locked write", v, 32'h0000_1234);
    kwr(6'h20, 32'hFFFF, 1'b0);

    // R5 vector table
    foreach (VEC[i]) begin
      kwr(6'h08, {1'b0, VEC[i][46:16]}, 1'b0);
      kwr(6'h00, {28'b0, VEC[i][50:47]}, 1'b0);
      rd(6'h10, v); check("R5 scaled", v, {16'b0, VEC[i][15:0]});
    end
    wr(6'h10, 32'h0, 1'b0);
    rd(6'h10, v); check("R5 write ignored", v, 32'h0000_0008);

    // R4 counting
    kwr(6'h08, 32'h0, 1'b0);
    kwr(6'h00, 32'h1000, 1'b0);
    ticks(5);
    rd(6'h08, v); check("R4 count always", v, 32'd5);
    kwr(6'h00, 32'h0, 1'b0);
    ticks(3);
    rd(6'h08, v); check("R4 hold disabled", v, 32'd5);
    kwr(6'h00, 32'h2000, 1'b0);
    ticks(2);
    rd(6'h08, v); check("R4 count awake", v, 32'd7);
    kwr(6'h08, 32'hFFFF_FFFF, 1'b0);
    rd(6'h08, v); check("R4 msb zero", v, 32'h7FFF_FFFF);
    ticks(1);
    rd(6'h08, v); check("R4 wrap", v, 32'h0);

    // R10 load beats tick
    kwr(6'h08, 32'h100, 1'b1);
    rd(6'h08, v); check("R10 load over tick", v, 32'h100);

    // R6 feed
    kwr(6'h18, 32'h1111_2222, 1'b0);
    rd(6'h08, v); check("R6 wrong feed", v, 32'h100);
    rd(6'h1C, v); check("R6 key used", v, 32'h0);
    kwr(6'h18, FEED, 1'b0);
    rd(6'h08, v); check("R6 feed clears", v, 32'h0);

    // R7 compare and sticky pending
    kwr(6'h00, 32'h1000, 1'b0);
    kwr(6'h20, 32'd3, 1'b0);
    ticks(3);
    check("R7 irq before", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 irq set", {31'b0, irq}, 32'h1);
    rd(6'h00, v); check("R7 pend bit", v, 32'h1000_1000);
    kwr(6'h00, 32'h1000, 1'b0);
    check("R7 match resets pend", {31'b0, irq}, 32'h1);
    kwr(6'h18, FEED, 1'b0);
    kwr(6'h00, 32'h1000, 1'b0);
    check("R7 pend cleared", {31'b0, irq}, 32'h0);
    check("R9 no req without enable", n_pulse, 0);

    // R8 zero on compare
    kwr(6'h00, 32'h1200, 1'b0);
    ticks(3);
    @(negedge clk);
    rd(6'h08, v); check("R8 count zeroed", v, 32'h0);
    check("R8 irq", {31'b0, irq}, 32'h1);
    check("R9 no req with bit8 clear", n_pulse, 0);

    // R9 reset request
    kwr(6'h00, 32'h1100, 1'b0);
    ticks(3);
    repeat (6) @(negedge clk);
    check("R9 single pulse", n_pulse, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule